// File: doc/BRIEF.md
# IR Run-Length Receive Sampler

This block turns a demodulated infrared receiver signal into a stream of run-length bytes. It samples the signal once per selected sample tick and measures how long each constant level lasts. When the level changes, or a run grows too long for one byte, it writes a byte into a small receive queue. Each byte holds the level in its top bit and the run length, less one, in the low seven bits.

Software, or a neighbouring block, drains the queue through a show-ahead read port. Sample ticks arrive from an outside baud generator at the fine rate. A mode input selects either every tick, or every fifth tick counted from reset, as the sampling instant. A polarity option flips the raw input. A disable strobe throws away the run in progress and parks the receiver until a pulse appears again. A threshold interrupt tells the reader that half the queue is full. A sticky overrun flag records a byte lost to a full queue.

Top module: `ir_rle_sampler`

## Requirements
- R1: Each queued byte has bit 7 = level (1 = space, 0 = pulse) and bits 6:0 = run length in samples minus one. A byte for the finished run is queued on the first sample whose level differs from that run.
- R2: When a run reaches 128 samples, the next sample of the same level queues a byte with field 127 and starts a new run of that level with length one. A run of exactly 128 samples followed by a level change yields a single byte with field 127.
- R3: With `fine_sel` = 1 every `sample_tick` pulse is a sample. With `fine_sel` = 0 only every fifth `sample_tick` pulse counted from reset is a sample (the 5th, 10th, ...). Other pulses have no effect.
- R4: The queue holds 16 bytes in arrival order. `rd_data` shows the oldest byte, and a cycle with `rd_en` high removes it. `data_avail` is high exactly when the queue is not empty.
- R5: `thr_irq` is high exactly when 8 or more bytes are queued.
- R6: A byte produced while the queue is full (and not being read that cycle) is dropped and sets `overrun`. `overrun` stays set until a cycle with `status_rd` high clears it. The queued bytes are unaffected.
- R7: A cycle with `rx_disable` high discards the run in progress and makes the receiver idle. While idle no bytes are produced, and the receiver leaves idle on the first sample that shows a pulse, which starts a pulse run of length one.
- R8: With `invert` = 1 the raw input is complemented before sampling, so raw high reads as a pulse.
- R9: After reset the queue is empty, `data_avail`, `thr_irq` and `overrun` are low, and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle pulse at the fine sample rate |
| fine_sel | input | 1 | 1: sample on every tick; 0: sample on every fifth tick |
| ir_raw | input | 1 | Demodulated receiver input (asynchronous) |
| invert | input | 1 | Complement the raw input before sampling |
| rx_disable | input | 1 | Strobe: discard the current run and go idle |
| rd_en | input | 1 | Remove the oldest queued byte |
| status_rd | input | 1 | Strobe: clear the overrun flag |
| rd_data | output | 8 | Oldest queued byte (level, run length minus one) |
| data_avail | output | 1 | Queue is not empty |
| thr_irq | output | 1 | At least 8 bytes queued |
| overrun | output | 1 | Sticky: a byte was lost to a full queue |

## Verification
The properties assume that `sample_tick` is a clean one-cycle strobe and that `rx_disable` and `status_rd` are single-cycle strobes. They also assume that `ir_raw` changes slowly compared with the clock, so the synchronizer delay never moves an edge across a sample. The stimulus changes `ir_raw` only between ticks, and then waits three clock cycles before the next tick. It spaces ticks two cycles apart and pulses every strobe for exactly one cycle. When the coarse mode is used, the test starts from a reset, so the five-tick phase is known.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;
   localparam int RUN_W   = 7;
   localparam int BYTE_W  = RUN_W + 1;
   localparam logic [RUN_W-1:0] RUN_MAX = '1;

   localparam logic LVL_PULSE = 1'b0;
   localparam logic LVL_SPACE = 1'b1;

   typedef struct packed {
      logic             level;
      logic [RUN_W-1:0] run_m1;
   } rle_byte_t;

   typedef enum logic {
      RX_IDLE   = 1'b0,
      RX_ACTIVE = 1'b1
   } rx_state_e;
endpackage

// File: rtl/ir_rx_cond.sv
module ir_rx_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ir_raw,
   input  logic invert,
   output logic lvl
);
   logic synced;

   generate
      if (SYNC_STAGES == 0) begin : g_bypass
         assign synced = ir_raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], ir_raw};
         end
         assign synced = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign lvl = synced ^ invert;
endmodule

// File: rtl/ir_tick_sel.sv
module ir_tick_sel #(
   parameter int COARSE_DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_tick,
   input  logic fine_sel,
   output logic sample_en
);
   generate
      if (COARSE_DIV == 1) begin : g_nodiv
         assign sample_en = sample_tick;
      end else begin : g_div
         localparam int DW = $clog2(COARSE_DIV);
         localparam logic [DW-1:0] LAST = DW'(COARSE_DIV - 1);
         logic [DW-1:0] phase;
         always_ff @(posedge clk) begin
            if (!rst_n)           phase <= '0;
            else if (sample_tick) phase <= (phase == LAST) ? '0 : phase + 1'b1;
         end
         assign sample_en = sample_tick && (fine_sel || phase == LAST);
      end
   endgenerate
endmodule

// File: rtl/ir_rle_enc.sv
module ir_rle_enc
   import ir_rle_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sample_en,
   input  logic      lvl,
   input  logic      rx_disable,
   output logic      push,
   output rle_byte_t push_byte
);
   rx_state_e        state;
   logic             cur_lvl;
   logic [RUN_W-1:0] run_cnt;
   logic             changed;
   logic             saturated;

   assign changed   = (lvl != cur_lvl);
   assign saturated = (run_cnt == RUN_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         cur_lvl <= LVL_SPACE;
         run_cnt <= '0;
      end else if (rx_disable) begin
         state   <= RX_IDLE;
         run_cnt <= '0;
      end else if (sample_en) begin
         unique case (state)
            RX_IDLE: begin
               if (lvl == LVL_PULSE) begin
                  state   <= RX_ACTIVE;
                  cur_lvl <= LVL_PULSE;
                  run_cnt <= '0;
               end
            end
            RX_ACTIVE: begin
               if (changed) begin
                  cur_lvl <= lvl;
                  run_cnt <= '0;
               end else if (saturated) begin
                  run_cnt <= '0;
               end else begin
                  run_cnt <= run_cnt + 1'b1;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   assign push = (state == RX_ACTIVE) && sample_en && !rx_disable &&
                 (changed || saturated);
   assign push_byte.level  = cur_lvl;
   assign push_byte.run_m1 = run_cnt;
endmodule

// File: rtl/ir_rle_fifo.sv
module ir_rle_fifo #(
   parameter int DEPTH  = 16,
   parameter int WIDTH  = 8,
   parameter int THRESH = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic [WIDTH-1:0]              wdata,
   input  logic                          pop,
   output logic [WIDTH-1:0]              rdata,
   output logic                          empty,
   output logic                          full,
   output logic                          at_thresh,
   output logic                          drop,
   output logic [$clog2(DEPTH+1)-1:0]    count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             pop_ok, push_ok;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign drop    = push && !push_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         unique case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   assign rdata     = mem[rd_ptr];
   assign at_thresh = (count >= CW'(THRESH));
endmodule

// File: rtl/ir_rle_sampler.sv
module ir_rle_sampler
   import ir_rle_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int THRESH      = 8,
   parameter int COARSE_DIV  = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_tick,
   input  logic              fine_sel,
   input  logic              ir_raw,
   input  logic              invert,
   input  logic              rx_disable,
   input  logic              rd_en,
   input  logic              status_rd,
   output logic [BYTE_W-1:0] rd_data,
   output logic              data_avail,
   output logic              thr_irq,
   output logic              overrun
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ir_rle_sampler: DEPTH must be a power of two >= 2");
      end
      if (THRESH < 1 || THRESH > DEPTH) begin : g_bad_thresh
         $error("ir_rle_sampler: THRESH must lie in 1..DEPTH");
      end
      if (COARSE_DIV < 1) begin : g_bad_div
         $error("ir_rle_sampler: COARSE_DIV must be >= 1");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("ir_rle_sampler: SYNC_STAGES must be 0 or >= 2");
      end
   endgenerate

   logic      in_lvl;
   logic      sample_en;
   logic      enc_push;
   rle_byte_t enc_byte;
   logic      fifo_empty, fifo_full, fifo_drop;
   logic [CW-1:0] fifo_count;

   ir_rx_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk(clk), .rst_n(rst_n), .ir_raw(ir_raw), .invert(invert), .lvl(in_lvl)
   );

   ir_tick_sel #(.COARSE_DIV(COARSE_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
      .fine_sel(fine_sel), .sample_en(sample_en)
   );

   ir_rle_enc u_enc (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .lvl(in_lvl),
      .rx_disable(rx_disable), .push(enc_push), .push_byte(enc_byte)
   );

   ir_rle_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W), .THRESH(THRESH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(enc_push), .wdata(enc_byte),
      .pop(rd_en), .rdata(rd_data), .empty(fifo_empty), .full(fifo_full),
      .at_thresh(thr_irq), .drop(fifo_drop), .count(fifo_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         overrun <= 1'b0;
      else if (fifo_drop) overrun <= 1'b1;
      else if (status_rd) overrun <= 1'b0;
   end

   assign data_avail = !fifo_empty;
endmodule

// File: rtl/ir_rle_sampler_chk.sv
module ir_rle_sampler_chk #(
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          push,
   input logic          full,
   input logic          rd_en,
   input logic          rx_disable,
   input logic          status_rd,
   input logic          data_avail,
   input logic          thr_irq,
   input logic          overrun,
   input logic [CW-1:0] count
);
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   assert_avail_after_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
      push && !data_avail && !rd_en |=> data_avail);

   assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !push && !rd_en |=> $stable(count));

   assert_thr_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      thr_irq |-> data_avail);

   assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(push && full && !rd_en));

   assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      status_rd && !(push && full && !rd_en) |=> !overrun);

   assert_idle_after_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_disable |=> !push);
endmodule

bind ir_rle_sampler ir_rle_sampler_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH + 1))) u_chk (
   .clk(clk), .rst_n(rst_n), .push(enc_push), .full(fifo_full), .rd_en(rd_en),
   .rx_disable(rx_disable), .status_rd(status_rd), .data_avail(data_avail),
   .thr_irq(thr_irq), .overrun(overrun), .count(fifo_count)
);

// File: tb/ir_rle_sampler_tb.sv
module ir_rle_sampler_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n, sample_tick, fine_sel, ir_raw, invert;
   logic       rx_disable, rd_en, status_rd;
   logic [7:0] rd_data;
   logic       data_avail, thr_irq, overrun;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ir_rle_sampler u_dut (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .fine_sel(fine_sel),
      .ir_raw(ir_raw), .invert(invert), .rx_disable(rx_disable), .rd_en(rd_en),
      .status_rd(status_rd), .rd_data(rd_data), .data_avail(data_avail),
      .thr_irq(thr_irq), .overrun(overrun)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic fine, input logic inv);
      @(negedge clk);
      rst_n = 1'b0; sample_tick = 1'b0; rx_disable = 1'b0; rd_en = 1'b0;
      status_rd = 1'b0; fine_sel = fine; invert = inv; ir_raw = ~inv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   // hold raw level, let it cross the synchronizer, then issue n ticks
   task automatic run(input logic raw, input int n);
      ir_raw = raw;
      repeat (3) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         sample_tick = 1'b1;
         @(negedge clk);
         sample_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic strobe_disable();
      rx_disable = 1'b1;
      @(negedge clk);
      rx_disable = 1'b0;
      @(negedge clk);
   endtask

   task automatic read_expect(input string req, input logic [7:0] exp);
      check({req, " avail"}, {7'b0, data_avail}, 8'h01);
      check(req, rd_data, exp);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset(1'b1, 1'b0);
      check("R9 data_avail", {7'b0, data_avail}, 8'h00);
      check("R9 thr_irq", {7'b0, thr_irq}, 8'h00);
      check("R9 overrun", {7'b0, overrun}, 8'h00);
      run(1'b1, 20);  // space while idle: nothing queued
      check("R9 idle after reset", {7'b0, data_avail}, 8'h00);
   endtask

   task automatic t_basic_runs();
      do_reset(1'b1, 1'b0);
      run(1'b0, 5);
      run(1'b1, 3);
      run(1'b0, 1);
      strobe_disable();
      read_expect("R1 pulse 5", 8'h04);
      read_expect("R1 space 3", 8'h82);
      check("R4 empty after reads", {7'b0, data_avail}, 8'h00);
   endtask

   task automatic t_long_runs();
      do_reset(1'b1, 1'b0);
      run(1'b0, 130);
      run(1'b1, 1);
      strobe_disable();
      read_expect("R2 split full byte", 8'h7F);
      read_expect("R2 split remainder", 8'h01);
      run(1'b0, 128);
      run(1'b1, 1);
      strobe_disable();
      read_expect("R2 exactly 128", 8'h7F);
      check("R2 single byte for 128", {7'b0, data_avail}, 8'h00);
   endtask

   task automatic t_coarse();
      do_reset(1'b0, 1'b0);
      run(1'b0, 15);  // samples on ticks 5,10,15
      run(1'b1, 5);   // sample on tick 20
      run(1'b0, 5);   // sample on tick 25
      strobe_disable();
      read_expect("R3 coarse pulse", 8'h02);
      read_expect("R3 coarse space", 8'h80);
      check("R3 no extra bytes", {7'b0, data_avail}, 8'h00);
   endtask

   task automatic t_invert();
      do_reset(1'b1, 1'b1);
      run(1'b1, 3);
      run(1'b0, 2);
      run(1'b1, 1);
      strobe_disable();
      read_expect("R8 inverted pulse", 8'h02);
      read_expect("R8 inverted space", 8'h81);
   endtask

   task automatic t_fill_overrun();
      do_reset(1'b1, 1'b0);
      run(1'b0, 1);
      for (int i = 1; i <= 17; i++) begin
         run((i % 2 == 1) ? 1'b1 : 1'b0, 1);
         if (i == 7)  check("R5 below threshold", {7'b0, thr_irq}, 8'h00);
         if (i == 8)  check("R5 at threshold", {7'b0, thr_irq}, 8'h01);
         if (i == 16) check("R6 full no overrun", {7'b0, overrun}, 8'h00);
         if (i == 17) check("R6 overrun set", {7'b0, overrun}, 8'h01);
      end
      strobe_disable();
      check("R6 overrun sticky", {7'b0, overrun}, 8'h01);
      status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
      check("R6 overrun cleared", {7'b0, overrun}, 8'h00);
      for (int j = 1; j <= 16; j++) begin
         read_expect("R4 order", (j % 2 == 1) ? 8'h00 : 8'h80);
         if (j == 9) check("R5 drops below threshold", {7'b0, thr_irq}, 8'h00);
      end
      check("R6 dropped byte not queued", {7'b0, data_avail}, 8'h00);
   endtask

   task automatic t_disable();
      do_reset(1'b1, 1'b0);
      run(1'b0, 3);
      strobe_disable();
      run(1'b1, 200);
      check("R7 idle queues nothing", {7'b0, data_avail}, 8'h00);
      run(1'b0, 2);
      run(1'b1, 1);
      strobe_disable();
      read_expect("R7 fresh run after idle", 8'h01);
      check("R7 discarded run absent", {7'b0, data_avail}, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; sample_tick = 1'b0; fine_sel = 1'b1; ir_raw = 1'b1;
      invert = 1'b0; rx_disable = 1'b0; rd_en = 1'b0; status_rd = 1'b0;
      t_reset_state();
      t_basic_runs();
      t_long_runs();
      t_coarse();
      t_invert();
      t_fill_overrun();
      t_disable();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule